// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides when one of several interrupt request lines may break into the processor. Every line carries a 2-bit urgency code supplied on an input port. The block keeps a record of each request that has been raised but not yet granted. It also holds one global enable flag and a small stack with the urgency of every handler that is currently running. A request is granted only when the flag is set and the request is strictly more urgent than the handler on top of the stack. An empty stack stands for background code, which every level can preempt.

The processor side reports three events on single-cycle strobes: interrupts re-enabled, return from handler, and one instruction retired. A grant produces a one-cycle pulse carrying the winning line's index. At the same time it pushes that line's level onto the stack and clears the enable flag. A return pops the stack and sets the flag again. When the return lands back in background code, a held request must wait until one background instruction has retired.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Urgency code 0 is the most urgent and code 3 the least; `cur_lvl_o` reports the top-of-stack code, or 4 when the stack is empty, and any code is more urgent than 4.
- R2: A grant clears `ien_o` and raises `grant_o` for exactly one cycle, with the line's index on `grant_idx_o`; a request sampled at clock edge k can raise `grant_o` no earlier than after edge k+1.
- R3: No grant is made while `ien_o` is 0; an `ei_i` strobe sets `ien_o` to 1 after the next edge.
- R4: A pending request is granted only if its code is strictly smaller than `cur_lvl_o`; a request at an equal or larger code stays pending.
- R5: A `reti_i` strobe sets `ien_o` to 1 and pops one stack entry; no grant is made in a cycle with `reti_i` high; with an empty stack it pops nothing.
- R6: A return that empties the stack blocks all grants until a `retire_i` strobe has been sampled; the grant can come at the earliest one cycle after that strobe. A return on an already empty stack does not arm this block.
- R7: Among eligible pending requests the smallest code wins, and ties go to the lowest index.
- R8: A `req_i` bit sets that line's pending bit, which stays set until that line is granted.
- R9: Reset clears every pending bit, empties the stack, clears `ien_o` and `grant_o`, and drops the post-return block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NREQ | Request strobes, one per line |
| prio_i | input | 2*NREQ | Urgency code of line i in bits [2i+1:2i] |
| ei_i | input | 1 | Enable-interrupts event |
| reti_i | input | 1 | Return-from-handler event |
| retire_i | input | 1 | One instruction retired |
| grant_o | output | 1 | One-cycle grant pulse |
| grant_idx_o | output | IW | Index of the granted line |
| ien_o | output | 1 | Global enable flag |
| cur_lvl_o | output | 3 | Level in service, 4 for background |
| depth_o | output | 3 | Number of stacked handlers |

## Verification
The assertions assume that the processor side behaves: `reti_i` comes only while a handler is stacked, or as an isolated strobe on an empty stack, and `prio_i` stays constant while requests are pending. Under those conditions the stack can never grow past four entries. The stimulus table keeps one urgency map for the whole run and raises every strobe for a single cycle. It issues returns only to unwind handlers that it has entered itself, plus one deliberate return on an empty stack.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NREQ = 8,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_i,
  input  logic [2*NREQ-1:0] prio_i,
  input  logic              ei_i,
  input  logic              reti_i,
  input  logic              retire_i,
  output logic              grant_o,
  output logic [IW-1:0]     grant_idx_o,
  output logic              ien_o,
  output logic [2:0]        cur_lvl_o,
  output logic [2:0]        depth_o
);

  logic [NREQ-1:0] pend;
  logic [1:0]      stk [4];
  logic            bg_wait;
  logic [2:0]      best_lvl;
  logic [IW-1:0]   best_idx;
  logic            take;

  assign cur_lvl_o = (depth_o == 3'd0) ? 3'd4 : {1'b0, stk[depth_o[1:0] - 2'd1]};

  always_comb begin
    best_lvl = 3'd4;
    best_idx = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (pend[i] && ({1'b0, prio_i[2*i +: 2]} < best_lvl)) begin
        best_lvl = {1'b0, prio_i[2*i +: 2]};
        best_idx = IW'(i);
      end
    end
  end

  assign take = ien_o && !bg_wait && !reti_i && (best_lvl < cur_lvl_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= '0;
      bg_wait     <= 1'b0;
      ien_o       <= 1'b0;
      depth_o     <= 3'd0;
      grant_o     <= 1'b0;
      grant_idx_o <= '0;
      for (int k = 0; k < 4; k++) stk[k] <= 2'd0;
    end else begin
      grant_o <= take;
      pend    <= (pend & ~(take ? (NREQ'(1) << best_idx) : '0)) | req_i;
      if (retire_i) bg_wait <= 1'b0;
      if (take) begin
        grant_idx_o         <= best_idx;
        stk[depth_o[1:0]]   <= best_lvl[1:0];
        depth_o             <= depth_o + 3'd1;
        ien_o               <= 1'b0;
      end else if (reti_i) begin
        ien_o <= 1'b1;
        if (depth_o != 3'd0) begin
          depth_o <= depth_o - 3'd1;
          if (depth_o == 3'd1) bg_wait <= 1'b1;
        end
      end else if (ei_i) begin
        ien_o <= 1'b1;
      end
    end
  end

endmodule

module nest_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       grant_o,
  input logic       ien_o,
  input logic       reti_i,
  input logic [2:0] cur_lvl_o,
  input logic [2:0] depth_o
);
  // R2
  grant_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n) grant_o |-> !ien_o);
  // R3
  grant_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(grant_o) |-> $past(ien_o));
  // R4
  strictly_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(grant_o) |-> cur_lvl_o < $past(cur_lvl_o));
  // R2
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) grant_o |=> !grant_o);
  // R5
  reti_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n) reti_i |=> ien_o && !grant_o);
  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) depth_o <= 3'd4);
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .grant_o(grant_o), .ien_o(ien_o),
  .reti_i(reti_i), .cur_lvl_o(cur_lvl_o), .depth_o(depth_o)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  localparam int NREQ = 8;
  localparam int IW = 3;
  localparam int NV = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0] req_i = '0;
  logic [2*NREQ-1:0] prio_i = 16'h1B1B;
  logic ei_i = 1'b0, reti_i = 1'b0, retire_i = 1'b0;
  logic grant_o, ien_o;
  logic [IW-1:0] grant_idx_o;
  logic [2:0] cur_lvl_o, depth_o;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl #(.NREQ(NREQ)) i_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
    .ei_i(ei_i), .reti_i(reti_i), .retire_i(retire_i),
    .grant_o(grant_o), .grant_idx_o(grant_idx_o), .ien_o(ien_o),
    .cur_lvl_o(cur_lvl_o), .depth_o(depth_o)
  );

  // line codes: 0->3 1->2 2->1 3->0 4->3 5->2 6->1 7->0
  // row: req, {ei,reti,retire}, grant, idx, ien, lvl (after the edge)
  localparam logic [18:0] VEC [NV] = '{
    {8'h00, 3'b100, 1'b0, 3'd0, 1'b1, 3'd4},
    {8'h01, 3'b000, 1'b0, 3'd0, 1'b1, 3'd4},
    {8'h00, 3'b000, 1'b1, 3'd0, 1'b0, 3'd3},
    {8'h02, 3'b000, 1'b0, 3'd0, 1'b0, 3'd3},
    {8'h00, 3'b000, 1'b0, 3'd0, 1'b0, 3'd3},
    {8'h00, 3'b100, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b000, 1'b1, 3'd1, 1'b0, 3'd2},
    {8'h04, 3'b100, 1'b0, 3'd0, 1'b1, 3'd2},
    {8'h00, 3'b000, 1'b1, 3'd2, 1'b0, 3'd1},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd2},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h10, 3'b000, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b000, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd4},
    {8'h00, 3'b000, 1'b0, 3'd0, 1'b1, 3'd4},
    {8'h00, 3'b001, 1'b0, 3'd0, 1'b1, 3'd4},
    {8'h00, 3'b000, 1'b1, 3'd4, 1'b0, 3'd3},
    {8'hC8, 3'b000, 1'b0, 3'd0, 1'b0, 3'd3},
    {8'h00, 3'b100, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b000, 1'b1, 3'd3, 1'b0, 3'd0},
    {8'h00, 3'b100, 1'b0, 3'd0, 1'b1, 3'd0},
    {8'h00, 3'b000, 1'b0, 3'd0, 1'b1, 3'd0},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b000, 1'b1, 3'd7, 1'b0, 3'd0},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b000, 1'b1, 3'd6, 1'b0, 3'd1},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd3},
    {8'h00, 3'b010, 1'b0, 3'd0, 1'b1, 3'd4},
    {8'h00, 3'b001, 1'b0, 3'd0, 1'b1, 3'd4}
  };
  string tags [NV] = '{"R3","R8","R1","R2","R3","R3","R4","R3","R4","R5",
                       "R5","R8","R4","R5","R6","R6","R6","R8","R3","R7",
                       "R3","R4","R5","R7","R5","R7","R5","R6","R6"};

  task automatic check(string tag, logic g, logic [IW-1:0] idx, logic en, logic [2:0] lvl);
    checks++;
    if (grant_o !== g || (g && grant_idx_o !== idx) || ien_o !== en || cur_lvl_o !== lvl) begin
      errors++;
      $display("FAIL %s: got g=%b idx=%0d ien=%b lvl=%0d, want g=%b idx=%0d ien=%b lvl=%0d",
               tag, grant_o, grant_idx_o, ien_o, cur_lvl_o, g, idx, en, lvl);
    end
  endtask

  task automatic step(logic [7:0] rq, logic [2:0] ev);
    req_i = rq; {ei_i, reti_i, retire_i} = ev;
    @(posedge clk); @(negedge clk);
    req_i = '0; {ei_i, reti_i, retire_i} = 3'b000;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hung run, want completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9 reset state
    check("R9", 1'b0, '0, 1'b0, 3'd4);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][18:11], VEC[v][10:8]);
      check(tags[v], VEC[v][7], VEC[v][6:4], VEC[v][3], VEC[v][2:0]);
    end
    // R5 return on empty stack: no pop, flag set, R6 block not armed
    step(8'h00, 3'b010);
    check("R5", 1'b0, '0, 1'b1, 3'd4);
    checks++;
    if (depth_o !== 3'd0) begin
      errors++;
      $display("FAIL R5: got depth=%0d, want depth=0", depth_o);
    end
    step(8'h01, 3'b000);
    step(8'h00, 3'b000);
    check("R6", 1'b1, 3'd0, 1'b0, 3'd3);
    // R9 reset mid-run drops pending and stack
    step(8'h08, 3'b100);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", 1'b0, '0, 1'b0, 3'd4);
    rst_n = 1'b1;
    step(8'h00, 3'b100);
    step(8'h00, 3'b000);
    check("R9", 1'b0, '0, 1'b1, 3'd4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule